// File: doc/BRIEF.md
# Ramp-Sampling DAC Timing Generator

This block produces the digital timing for a converter that turns a data code into an analog level by sampling an external linear ramp. A free-running frame counter advances once per tick, where one tick is a fixed number of system clocks. Near the end of each frame a ramp-run output drops so that the external ramp capacitor can discharge. Each channel has a compare output. It is high from the start of the frame until the counter reaches the channel's code plus a fixed offset. The offset keeps the sample point clear of the curved start of the ramp.

When a channel's compare output falls, a fixed-width sample strobe follows. That strobe drives an external sample-and-hold, so every frame yields one conversion per channel. The channels share the counter and the ramp-run output. Each channel holds its code in two stages: a write lands in a pending register, and the pending value becomes live only when the counter wraps. A frame therefore never sees a code change partway through.

Top module: `ramp_dac_timer`

## Requirements
- R1: The frame counter advances once every TICK_DIV (4) clocks and runs over counts 0 to 1199, so one frame lasts 4800 clocks.
- R2: `ramp_run` is high at counts 0 to 1169 and low at counts 1170 to 1199.
- R3: Each `cmp_out` bit is high from count 0 until the count before code+88. It is low from count code+88 to the end of the frame.
- R4: The fall count is linear in the code. Code 0 falls at count 88, 256 at 344, 512 at 600, and 1023 at 1111.
- R5: Each `smp_stb` bit is high for exactly 24 counts (96 clocks), starting at the count where that channel's `cmp_out` falls.
- R6: For every code, the strobe ends before `ramp_run` drops.
- R7: `wr_en[i]` stores the slice `wr_data[10*i+9:10*i]` as a pending code. The live code takes the pending value that is held just before the clock edge where the counter goes from 1199 to 0. A write made on that same edge takes effect one frame later.
- R8: Channels are independent. A write to one channel leaves the timing of the other channels unchanged.
- R9: Synchronous reset clears the counter, the prescaler and all codes. While `rst` is high, `ramp_run`, `cmp_out` and `smp_stb` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | NCH (3) | Per-channel code write enable |
| wr_data | input | NCH*CODE_W (30) | Codes packed per channel, channel i in bits 10*i+9:10*i |
| ramp_run | output | 1 | High while the ramp may charge, low during the discharge window |
| cmp_out | output | NCH (3) | Per-channel compare waveform |
| smp_stb | output | NCH (3) | Per-channel sample strobe |

## Verification
The case hardest to reach from the ports is a write that lands on the exact clock edge where the counter wraps. That write must not reach the live code until a frame later, and a window of one clock in 4800 is seldom hit by chance. The stimulus aims writes at that edge on purpose. Random writes at random points in the frame, with codes weighted toward 0 and 1023, then cover double buffering and the latest possible strobe. A reset in the middle of a frame checks that all codes return to zero.

// File: rtl/ramp_dac_timer.sv
module ramp_dac_timer #(
  parameter int TICK_DIV    = 4,
  parameter int PERIOD      = 1200,
  parameter int RAMP_LOW_AT = 1170,
  parameter int CODE_W      = 10,
  parameter int CODE_OFS    = 88,
  parameter int STB_TICKS   = 24,
  parameter int NCH         = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        wr_en,
  input  logic [NCH*CODE_W-1:0] wr_data,
  output logic                  ramp_run,
  output logic [NCH-1:0]        cmp_out,
  output logic [NCH-1:0]        smp_stb
);
  localparam int CW = $clog2(PERIOD);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int XW = CW + 1;

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic          active;
  logic          tick;
  logic          wrap;
  logic          en;
  logic [NCH-1:0][CODE_W-1:0] pend;
  logic [NCH-1:0][CODE_W-1:0] live;

  assign tick = (pre == PW'(TICK_DIV - 1));
  assign wrap = tick && (cnt == CW'(PERIOD - 1));
  assign en   = active && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else begin
      active <= 1'b1;
      pre    <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assign ramp_run = en && (cnt < CW'(RAMP_LOW_AT));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [XW-1:0] fall_at;
    logic [XW-1:0] stb_end;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= '0;
        live[i] <= '0;
      end else begin
        if (wr_en[i]) pend[i] <= wr_data[i*CODE_W +: CODE_W];
        if (wrap)     live[i] <= pend[i];
      end
    end

    assign fall_at    = XW'(live[i]) + XW'(CODE_OFS);
    assign stb_end    = fall_at + XW'(STB_TICKS);
    assign cmp_out[i] = en && ({1'b0, cnt} < fall_at);
    assign smp_stb[i] = en && ({1'b0, cnt} >= fall_at) && ({1'b0, cnt} < stb_end);
  end
endmodule

// File: rtl/ramp_dac_timer_chk.sv
module ramp_dac_timer_chk #(
  parameter int PERIOD      = 1200,
  parameter int RAMP_LOW_AT = 1170,
  parameter int NCH         = 3,
  parameter int CW          = 11,
  parameter int CODE_W      = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick,
  input logic                       wrap,
  input logic [CW-1:0]              cnt,
  input logic                       ramp_run,
  input logic [NCH-1:0]             cmp_out,
  input logic [NCH-1:0]             smp_stb,
  input logic [NCH-1:0][CODE_W-1:0] live
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(PERIOD)); // R1

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == (($past(cnt) == CW'(PERIOD - 1)) ? '0 : $past(cnt) + 1'b1))); // R1

  AST_RAMP_FALL_POINT: assert property (@(posedge clk) disable iff (rst)
    $fell(ramp_run) |-> (cnt == CW'(RAMP_LOW_AT))); // R2

  AST_STROBE_BEFORE_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
    (|smp_stb) |-> ramp_run); // R6

  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(live)); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
      smp_stb[i] |-> !cmp_out[i]); // R5
  end

  always_comb begin
    if (rst) begin
      AST_QUIET_IN_RESET: assert (!ramp_run && cmp_out == '0 && smp_stb == '0); // R9
    end
  end
endmodule

bind ramp_dac_timer ramp_dac_timer_chk #(
  .PERIOD(PERIOD), .RAMP_LOW_AT(RAMP_LOW_AT), .NCH(NCH), .CW(CW), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wrap(wrap), .cnt(cnt),
  .ramp_run(ramp_run), .cmp_out(cmp_out), .smp_stb(smp_stb), .live(live)
);

// File: tb/sim_ramp_dac_timer.sv
module sim_ramp_dac_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int PER = 1200;
  localparam int LOWAT = 1170;
  localparam int OFS = 88;
  localparam int SW = 24;
  localparam int NC = 3;

  logic          clk = 0;
  logic          rst = 1;
  logic [NC-1:0] wr_en = '0;
  logic [29:0]   wr_data = '0;
  logic          ramp_run;
  logic [NC-1:0] cmp_out;
  logic [NC-1:0] smp_stb;

  int checks = 0;
  int fails = 0;
  bit live_chk = 0;

  int m_pre, m_cnt;
  bit m_act;
  int m_pend[NC];
  int m_live[NC];

  ramp_dac_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
                     .ramp_run(ramp_run), .cmp_out(cmp_out), .smp_stb(smp_stb));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= 0; m_cnt <= 0; m_act <= 0;
      for (int i = 0; i < NC; i++) begin m_pend[i] <= 0; m_live[i] <= 0; end
    end else begin
      m_act <= 1;
      m_pre <= (m_pre == DIV-1) ? 0 : m_pre + 1;
      if (m_pre == DIV-1) m_cnt <= (m_cnt == PER-1) ? 0 : m_cnt + 1;
      for (int i = 0; i < NC; i++) begin
        if (wr_en[i]) m_pend[i] <= int'(wr_data[i*10 +: 10]);
        if (m_pre == DIV-1 && m_cnt == PER-1) m_live[i] <= m_pend[i];
      end
    end
  end

  function automatic bit e_ramp(int c, bit a, bit r);
    return a && !r && c < LOWAT;
  endfunction
  function automatic bit e_cmp(int c, int code, bit a, bit r);
    return a && !r && c < code + OFS;
  endfunction
  function automatic bit e_stb(int c, int code, bit a, bit r);
    return a && !r && c >= code + OFS && c < code + OFS + SW;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live_chk) begin
      bit er;
      bit [NC-1:0] ec, es;
      er = e_ramp(m_cnt, m_act, rst);
      for (int i = 0; i < NC; i++) begin
        ec[i] = e_cmp(m_cnt, m_live[i], m_act, rst);
        es[i] = e_stb(m_cnt, m_live[i], m_act, rst);
      end
      checks++;
      if (ramp_run !== er) begin fails++; $display("FAIL R2: ramp_run actual %0b expected %0b cnt %0d", ramp_run, er, m_cnt); end
      if (cmp_out !== ec) begin fails++; $display("FAIL R3: cmp_out actual %b expected %b cnt %0d", cmp_out, ec, m_cnt); end
      if (smp_stb !== es) begin fails++; $display("FAIL R5: smp_stb actual %b expected %b cnt %0d", smp_stb, es, m_cnt); end
    end
  end

  task automatic wr(int ch, int code);
    @(negedge clk); #1;
    wr_en = '0; wr_en[ch] = 1'b1;
    wr_data[ch*10 +: 10] = 10'(code);
    @(negedge clk); #1;
    wr_en = '0;
  endtask

  task automatic wait_cnt(int v);
    do @(negedge clk); while (!(m_cnt == v && m_pre == 0));
  endtask

  task automatic expect_fall(int ch, int at, string req);
    wait_cnt(at - 1);
    chk(cmp_out[ch] === 1'b1, req, int'(cmp_out[ch]), 1);
    wait_cnt(at);
    chk(cmp_out[ch] === 1'b0, req, int'(cmp_out[ch]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(ramp_run === 0 && cmp_out === '0 && smp_stb === '0, "R9",
        int'({ramp_run, cmp_out, smp_stb}), 0);
    #1 rst = 0;
    live_chk = 1;

    // R1: frame length measured between rising edges of ramp_run
    begin
      int n = 0;
      wait_cnt(1);
      wait_cnt(0);
      do begin @(negedge clk); n++; end while (!(m_cnt == 0 && m_pre == 0));
      chk(n == PER*DIV, "R1", n, PER*DIV);
    end

    // R2: discharge window edges
    wait_cnt(LOWAT - 1);
    chk(ramp_run === 1, "R2", int'(ramp_run), 1);
    wait_cnt(LOWAT);
    chk(ramp_run === 0, "R2", int'(ramp_run), 0);

    // R4: mapping of boundary codes
    wr(0, 0); wr(1, 256); wr(2, 1023);
    wait_cnt(0);
    expect_fall(0, 88, "R4");
    expect_fall(1, 344, "R4");
    expect_fall(2, 1111, "R4");

    // R5/R6: strobe width for the latest code, end before discharge
    begin
      int n = 0;
      wait_cnt(0);
      wait_cnt(1111);
      while (smp_stb[2] === 1'b1) begin n++; @(negedge clk); end
      chk(n == SW*DIV, "R5", n, SW*DIV);
      chk(m_cnt < LOWAT, "R6", m_cnt, LOWAT);
    end

    // R7: a write in mid-frame waits for the wrap
    wait_cnt(100);
    wr(1, 512);
    wait_cnt(400);
    chk(cmp_out[1] === 1'b0, "R7", int'(cmp_out[1]), 0);
    wait_cnt(0);
    wait_cnt(400);
    chk(cmp_out[1] === 1'b1, "R7", int'(cmp_out[1]), 1);
    expect_fall(1, 600, "R4");

    // R7: a write on the wrap edge lands one frame later
    wait_cnt(PER - 1);
    repeat (DIV - 2) @(negedge clk);
    wr(0, 700);
    wait_cnt(200);
    chk(cmp_out[0] === 1'b0, "R7", int'(cmp_out[0]), 0);
    wait_cnt(0);
    expect_fall(0, 788, "R7");

    // R8: channel 2 untouched by the writes above
    wait_cnt(0);
    expect_fall(2, 1111, "R8");

    // R9: reset in mid-frame clears codes
    wait_cnt(500);
    #1 rst = 1;
    repeat (3) @(negedge clk);
    chk(ramp_run === 0 && cmp_out === '0 && smp_stb === '0, "R9",
        int'({ramp_run, cmp_out, smp_stb}), 0);
    #1 rst = 0;
    wait_cnt(0);
    expect_fall(2, 88, "R9");

    // Random writes, codes weighted to the ends
    for (int f = 0; f < 18; f++) begin
      int ch, code, at;
      ch = int'($urandom_range(0, NC-1));
      case ($urandom_range(0, 3))
        0: code = 0;
        1: code = 1023;
        default: code = int'($urandom_range(0, 1023));
      endcase
      at = int'($urandom_range(0, PER-2));
      wait_cnt(at);
      wr(ch, code);
      if ($urandom_range(0, 1) == 1) begin
        ch = (ch + 1) % NC;
        wr(ch, int'($urandom_range(0, 1023)));
      end
      wait_cnt(PER - 1);
    end
    wait_cnt(0);
    wait_cnt(PER - 1);

    live_chk = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule